// File: doc/BRIEF.md
# Four-Stage In-Order Instruction Pipeline with Hazard Control

This block is a small in-order processor core. Each instruction passes through four stages: fetch, decode with address calculation, operand fetch, and execute. The stage registers advance on every clock unless a hazard holds them back. The core runs a tiny instruction set: no-op, load, add, increment, jump, return-from-interrupt and halt. It has four 16-bit registers and a unified word-addressed memory. The memory is written through a load port while the core is held in reset.

The hazard logic covers three cases. First, a structural conflict occurs when only one memory port exists. Second, a register data dependency is handled by interlocking, because there is no forwarding. Third, control changes from jumps, interrupts and returns empty the pipe. A bubble is a stage register whose valid bit is clear and whose opcode is no-op. The core exposes the program counter, a per-stage valid and PC trace, the register file, stall and flush strobes, the saved return address, and running counts of stalled cycles and flush events. It is meant for checking pipeline timing rather than for throughput.

Top module: `fourstage_pipe`

## Requirements
- R1: An instruction word is 16 bits, decoded as follows. Bits [15:13] hold the opcode: 0 no-op, 1 load, 2 add, 3 increment, 4 jump, 5 return, 6 halt. Bits [12:11] hold rd, bits [10:9] hold rs, and bits [AW-1:0] hold addr. Load sets rd to mem[addr + rs]. Add sets rd to rd + rs. Increment sets rd to rd + 1. A register is written when its instruction leaves execute.
- R2: With DUAL_PORT=0, a valid load in operand fetch takes the memory port. In that cycle no instruction is fetched, the PC holds, stall_mem_o is 1 and a bubble enters decode.
- R3: With DUAL_PORT=1, stall_mem_o never rises, and a load in operand fetch costs no fetch cycle.
- R4: Suppose an instruction in decode reads a register that a valid instruction in operand fetch or execute will write. Then decode and fetch hold, a bubble enters operand fetch, and stall_data_o is 1. The instruction leaves decode in the cycle after the writer completes, so an adjacent dependency costs two bubbles.
- R5: A jump in decode sets the PC to its addr field. It also discards the instruction being fetched, bubbles operand fetch, and pulses flush_o for one cycle.
- R6: An interrupt request is latched. It is taken in a cycle where execute holds a valid instruction and no handler is active. That instruction still completes. All younger stages are discarded and the PC becomes IRQ_VEC. epc_o receives the PC of the oldest instruction that has not completed. Interrupt entry has priority over a jump decoded in the same cycle.
- R7: A return in decode sets the PC to epc_o, re-enables interrupts and flushes like a jump.
- R8: A halt in decode stops fetching and stays in decode. It counts as neither a stall nor a flush.
- R9: During reset the PC, stage valids, registers, epc_o, counters and strobes are all zero.
- R10: stall_cnt_o increments in every cycle where stall_data_o or stall_mem_o is 1. flush_cnt_o increments in every cycle where flush_o is 1.
- R11: stg_vld_o holds the valid bits of {execute, operand fetch, decode}, and stg_pc_o holds their PCs in the same order, with AW bits each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Memory load write enable |
| ld_addr | input | AW | Memory load address |
| ld_data | input | 16 | Memory load data |
| irq | input | 1 | Interrupt request pulse |
| pc_o | output | AW | Fetch program counter |
| stg_vld_o | output | 3 | Stage valids {EX, FO, DA} |
| stg_pc_o | output | 3*AW | Stage PCs {EX, FO, DA} |
| regs_o | output | 64 | Register file {r3, r2, r1, r0} |
| stall_data_o | output | 1 | Data interlock stall this cycle |
| stall_mem_o | output | 1 | Memory port stall this cycle |
| flush_o | output | 1 | Pipe flushed this cycle |
| epc_o | output | AW | Saved interrupt return PC |
| stall_cnt_o | output | CW | Count of stalled cycles |
| flush_cnt_o | output | CW | Count of flush events |

## Verification
Interrupt entry and jump resolution can fall in the same cycle. This happens when a jump reaches decode just as a valid instruction sits in execute with a request pending. The bench provokes the case with a program laid out as increment, no-op, jump. It raises the request so that entry coincides with the jump decode. It then judges the outcome in three ways. The return address must point at the no-op. The instructions skipped by the jump must still leave their registers untouched after the return. The flush count must show three separate events: entry, return and the re-executed jump.

// File: rtl/fourstage_pipe.sv
`timescale 1ns/1ps
module fourstage_pipe #(
  parameter int AW        = 6,
  parameter bit DUAL_PORT = 1'b0,
  parameter int IRQ_VEC   = 32,
  parameter int CW        = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_we,
  input  logic [AW-1:0]   ld_addr,
  input  logic [15:0]     ld_data,
  input  logic            irq,
  output logic [AW-1:0]   pc_o,
  output logic [2:0]      stg_vld_o,
  output logic [3*AW-1:0] stg_pc_o,
  output logic [63:0]     regs_o,
  output logic            stall_data_o,
  output logic            stall_mem_o,
  output logic            flush_o,
  output logic [AW-1:0]   epc_o,
  output logic [CW-1:0]   stall_cnt_o,
  output logic [CW-1:0]   flush_cnt_o
);
  localparam int W     = 16;
  localparam int NR    = 4;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] OP_NOP = 3'd0, OP_LD = 3'd1, OP_ADD = 3'd2, OP_INC = 3'd3,
                         OP_JMP = 3'd4, OP_RET = 3'd5, OP_HLT = 3'd6;

  logic [W-1:0]  mem [DEPTH];
  logic [W-1:0]  rf  [NR];
  logic [AW-1:0] pc, epc;
  logic          pend, in_isr;
  logic [CW-1:0] st_cnt, fl_cnt;

  logic          da_v;
  logic [AW-1:0] da_pc;
  logic [W-1:0]  da_ir;

  logic          fo_v;
  logic [AW-1:0] fo_pc, fo_ea;
  logic [2:0]    fo_op;
  logic [1:0]    fo_rd;
  logic [W-1:0]  fo_a, fo_b;

  logic          ex_v;
  logic [AW-1:0] ex_pc;
  logic [2:0]    ex_op;
  logic [1:0]    ex_rd;
  logic [W-1:0]  ex_a, ex_b, ex_res;

  logic [2:0]    d_op;
  logic [1:0]    d_rd, d_rs;
  logic [AW-1:0] d_addr, d_ea, br_tgt, ret_pc;
  logic          unused_ir;
  logic          rd_use, rs_use, fo_wr, ex_wr;
  logic          hz_data, hz_mem, take_int, branch, halt;
  logic [W-1:0]  f_word, d_word;

  assign d_op      = da_ir[15:13];
  assign d_rd      = da_ir[12:11];
  assign d_rs      = da_ir[10:9];
  assign d_addr    = da_ir[AW-1:0];
  assign unused_ir = ^da_ir[8:AW];
  assign d_ea      = d_addr + rf[d_rs][AW-1:0];

  assign rd_use = da_v && (d_op == OP_ADD || d_op == OP_INC);
  assign rs_use = da_v && (d_op == OP_LD  || d_op == OP_ADD);
  assign fo_wr  = fo_v && (fo_op == OP_LD || fo_op == OP_ADD || fo_op == OP_INC);
  assign ex_wr  = ex_v && (ex_op == OP_LD || ex_op == OP_ADD || ex_op == OP_INC);

  assign hz_data = (rd_use && ((fo_wr && fo_rd == d_rd) || (ex_wr && ex_rd == d_rd))) ||
                   (rs_use && ((fo_wr && fo_rd == d_rs) || (ex_wr && ex_rd == d_rs)));
  assign hz_mem   = !DUAL_PORT && fo_v && fo_op == OP_LD;
  assign take_int = pend && !in_isr && ex_v;
  assign branch   = da_v && (d_op == OP_JMP || d_op == OP_RET);
  assign halt     = da_v && d_op == OP_HLT;
  assign br_tgt   = (d_op == OP_RET) ? epc : d_addr;
  assign ret_pc   = fo_v ? fo_pc : (da_v ? da_pc : pc);

  generate
    if (DUAL_PORT) begin : g_two_port
      assign f_word = mem[pc];
      assign d_word = mem[fo_ea];
    end else begin : g_one_port
      logic [AW-1:0] port_a;
      assign port_a = hz_mem ? fo_ea : pc;
      assign f_word = mem[port_a];
      assign d_word = mem[port_a];
    end
  endgenerate

  always_comb begin
    case (ex_op)
      OP_LD:   ex_res = ex_b;
      OP_ADD:  ex_res = ex_a + ex_b;
      OP_INC:  ex_res = ex_a + 1'b1;
      default: ex_res = ex_a;
    endcase
  end

  always_ff @(posedge clk) begin
    if (ld_we) mem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0; epc <= '0; pend <= 1'b0; in_isr <= 1'b0;
      st_cnt <= '0; fl_cnt <= '0;
      da_v <= 1'b0; da_pc <= '0; da_ir <= '0;
      fo_v <= 1'b0; fo_pc <= '0; fo_ea <= '0; fo_op <= OP_NOP; fo_rd <= '0; fo_a <= '0; fo_b <= '0;
      ex_v <= 1'b0; ex_pc <= '0; ex_op <= OP_NOP; ex_rd <= '0; ex_a <= '0; ex_b <= '0;
      for (int i = 0; i < NR; i++) rf[i] <= '0;
    end else begin
      if (ex_wr) rf[ex_rd] <= ex_res;
      if (stall_data_o || stall_mem_o) st_cnt <= st_cnt + 1'b1;
      if (flush_o) fl_cnt <= fl_cnt + 1'b1;

      if (take_int) begin
        pend   <= irq;
        in_isr <= 1'b1;
        epc    <= ret_pc;
        pc     <= AW'(IRQ_VEC);
        da_v   <= 1'b0;
        fo_v   <= 1'b0; fo_op <= OP_NOP;
        ex_v   <= 1'b0; ex_op <= OP_NOP;
      end else begin
        pend  <= pend | irq;
        ex_v  <= fo_v;
        ex_pc <= fo_pc;
        ex_op <= fo_op;
        ex_rd <= fo_rd;
        ex_a  <= fo_a;
        ex_b  <= (fo_op == OP_LD) ? d_word : fo_b;

        if (hz_data || halt) begin
          fo_v <= 1'b0; fo_op <= OP_NOP;
        end else if (branch) begin
          fo_v <= 1'b0; fo_op <= OP_NOP;
          da_v <= 1'b0;
          pc   <= br_tgt;
          if (d_op == OP_RET) in_isr <= 1'b0;
        end else begin
          fo_v  <= da_v;
          fo_pc <= da_pc;
          fo_op <= da_v ? d_op : OP_NOP;
          fo_rd <= d_rd;
          fo_ea <= d_ea;
          fo_a  <= rf[d_rd];
          fo_b  <= rf[d_rs];
          if (hz_mem) begin
            da_v <= 1'b0;
          end else begin
            da_v  <= 1'b1;
            da_pc <= pc;
            da_ir <= f_word;
            pc    <= pc + 1'b1;
          end
        end
      end
    end
  end

  assign stall_data_o = hz_data && !take_int;
  assign stall_mem_o  = hz_mem && !take_int && !hz_data && !branch && !halt;
  assign flush_o      = take_int || branch;
  assign pc_o         = pc;
  assign epc_o        = epc;
  assign stall_cnt_o  = st_cnt;
  assign flush_cnt_o  = fl_cnt;
  assign stg_vld_o    = {ex_v, fo_v, da_v};
  assign stg_pc_o     = {ex_pc, fo_pc, da_pc};
  assign regs_o       = {rf[3], rf[2], rf[1], rf[0]};
endmodule

// File: rtl/fourstage_pipe_chk.sv
`timescale 1ns/1ps
module fourstage_pipe_chk #(
  parameter int AW        = 6,
  parameter bit DUAL_PORT = 1'b0,
  parameter int CW        = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] pc_o,
  input logic [2:0]    stg_vld_o,
  input logic          stall_data_o,
  input logic          stall_mem_o,
  input logic          flush_o,
  input logic [CW-1:0] stall_cnt_o,
  input logic [CW-1:0] flush_cnt_o
);
  AST_DATA_HOLD_PC: assert property (@(posedge clk) disable iff (!rst_n)
    stall_data_o |=> pc_o == $past(pc_o)); // R4
  AST_DATA_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall_data_o |=> !stg_vld_o[1]); // R4
  AST_MEM_HOLD_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    stall_mem_o |=> (pc_o == $past(pc_o)) && !stg_vld_o[0]); // R2
  AST_TWO_PORT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    DUAL_PORT |-> !stall_mem_o); // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> stg_vld_o[1:0] == 2'b00); // R5
  AST_FLUSH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> flush_cnt_o == $past(flush_cnt_o) + 1'b1); // R10
  AST_STALL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_data_o || stall_mem_o) |=> stall_cnt_o == $past(stall_cnt_o) + 1'b1); // R10
  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall_data_o || stall_mem_o) |=> $stable(stall_cnt_o)); // R10
endmodule

bind fourstage_pipe fourstage_pipe_chk #(.AW(AW), .DUAL_PORT(DUAL_PORT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc_o(pc_o), .stg_vld_o(stg_vld_o),
  .stall_data_o(stall_data_o), .stall_mem_o(stall_mem_o), .flush_o(flush_o),
  .stall_cnt_o(stall_cnt_o), .flush_cnt_o(flush_cnt_o)
);

// File: tb/tb_fourstage_pipe.sv
`timescale 1ns/1ps
module tb_fourstage_pipe;
  localparam int AW = 6;
  localparam int CW = 16;
  localparam int NT = 6;

  logic clk = 1'b0, rst_n = 1'b0, ld_we = 1'b0, irq = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [15:0]   ld_data = '0;
  always #2 clk = ~clk;

  logic [AW-1:0] pc, pc2, epc, epc2;
  logic [2:0] vld, vld2;
  logic [3*AW-1:0] spc, spc2;
  logic [63:0] regs, regs2;
  logic sd, sd2, sm, sm2, fl, fl2;
  logic [CW-1:0] sc, sc2, fc, fc2;

  fourstage_pipe #(.AW(AW), .DUAL_PORT(1'b0), .IRQ_VEC(32), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data), .irq(irq),
    .pc_o(pc), .stg_vld_o(vld), .stg_pc_o(spc), .regs_o(regs), .stall_data_o(sd),
    .stall_mem_o(sm), .flush_o(fl), .epc_o(epc), .stall_cnt_o(sc), .flush_cnt_o(fc));

  fourstage_pipe #(.AW(AW), .DUAL_PORT(1'b1), .IRQ_VEC(32), .CW(CW)) dut_dp (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data), .irq(irq),
    .pc_o(pc2), .stg_vld_o(vld2), .stg_pc_o(spc2), .regs_o(regs2), .stall_data_o(sd2),
    .stall_mem_o(sm2), .flush_o(fl2), .epc_o(epc2), .stall_cnt_o(sc2), .flush_cnt_o(fc2));

  // per test: program, irq, r0..r3, stalls one-port, stalls two-port, flushes, epc, final pc
  localparam int T_PROG [NT] = '{0, 1, 2, 3, 4, 5};
  localparam int T_IRQ  [NT] = '{0, 0, 0, 1, 1, 0};
  localparam int T_REG  [NT][4] = '{'{12,7,1,1}, '{0,2,2,0}, '{0,1,0,0},
                                    '{1,1,1,2},  '{1,0,0,1}, '{0,1,7,1}};
  localparam int T_SSP  [NT] = '{2, 4, 0, 0, 0, 3};
  localparam int T_SDP  [NT] = '{0, 4, 0, 0, 0, 2};
  localparam int T_FL   [NT] = '{0, 0, 1, 2, 3, 0};
  localparam int T_EPC  [NT] = '{0, 0, 0, 1, 1, 0};
  localparam int T_PC   [NT] = '{6, 4, 6, 5, 7, 4};

  int nchk = 0, errs = 0;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input int op, input int rd, input int rs, input int a);
    enc = {3'(op), 2'(rd), 2'(rs), 3'b000, 6'(a)};
  endfunction

  task automatic wr(input int a, input logic [15:0] d);
    ld_we = 1'b1; ld_addr = 6'(a); ld_data = d;
    @(negedge clk);
  endtask

  task automatic load_prog(input int p);
    for (int a = 0; a < 64; a++) wr(a, 16'h0000);
    wr(48, 16'd5); wr(49, 16'd7);
    case (p)
      0: begin wr(0, enc(1,0,1,48)); wr(1, enc(1,1,2,49)); wr(2, enc(3,2,0,0));
               wr(3, enc(3,3,0,0)); wr(4, enc(2,0,1,0)); wr(5, enc(6,0,0,0)); end
      1: begin wr(0, enc(3,1,0,0)); wr(1, enc(3,1,0,0)); wr(2, enc(2,2,1,0)); wr(3, enc(6,0,0,0)); end
      2: begin wr(0, enc(4,0,0,4)); wr(1, enc(3,0,0,0)); wr(2, enc(3,0,0,0));
               wr(3, enc(6,0,0,0)); wr(4, enc(3,1,0,0)); wr(5, enc(6,0,0,0)); end
      3: begin wr(0, enc(3,0,0,0)); wr(1, enc(3,1,0,0)); wr(2, enc(3,2,0,0));
               wr(3, enc(3,3,0,0)); wr(4, enc(6,0,0,0));
               wr(32, enc(3,3,0,0)); wr(33, enc(5,0,0,0)); end
      4: begin wr(0, enc(3,0,0,0)); wr(1, enc(0,0,0,0)); wr(2, enc(4,0,0,6));
               wr(3, enc(3,1,0,0)); wr(4, enc(3,1,0,0)); wr(5, enc(3,1,0,0)); wr(6, enc(6,0,0,0));
               wr(32, enc(3,3,0,0)); wr(33, enc(5,0,0,0)); end
      default: begin wr(0, enc(3,1,0,0)); wr(1, enc(1,2,1,48)); wr(2, enc(3,3,0,0)); wr(3, enc(6,0,0,0)); end
    endcase
    ld_we = 1'b0;
  endtask

  task automatic start(input int p);
    rst_n = 1'b0;
    @(negedge clk);
    load_prog(p);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #600000;
    nchk++; errs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset pc", 64'(pc), 0);
    chk("R9 reset stage valids", 64'(vld), 0);
    chk("R9 reset regs", regs, 0);
    chk("R9 reset counters", {32'(sc), 32'(fc)}, 0);
    chk("R9 reset strobes", {61'b0, sd, sm, fl}, 0);

    for (int t = 0; t < NT; t++) begin
      logic [63:0] er;
      er = {16'(T_REG[t][3]), 16'(T_REG[t][2]), 16'(T_REG[t][1]), 16'(T_REG[t][0])};
      start(T_PROG[t]);
      if (T_IRQ[t] != 0) begin
        @(negedge clk); irq = 1'b1;
        @(negedge clk); irq = 1'b0;
      end
      repeat (60) @(negedge clk);
      chk($sformatf("R1 R6 R7 regs test %0d", t), regs, er);
      chk($sformatf("R3 regs two-port test %0d", t), regs2, er);
      chk($sformatf("R2 R4 R10 stall count test %0d", t), 64'(sc), 64'(T_SSP[t]));
      chk($sformatf("R3 R4 stall count two-port test %0d", t), 64'(sc2), 64'(T_SDP[t]));
      chk($sformatf("R5 R6 R10 flush count test %0d", t), 64'(fc), 64'(T_FL[t]));
      chk($sformatf("R6 epc test %0d", t), 64'(epc), 64'(T_EPC[t]));
      chk($sformatf("R8 halted pc test %0d", t), 64'(pc), 64'(T_PC[t]));
    end

    // R4 R11 exact interlock timing
    start(1);
    @(negedge clk); @(negedge clk);
    chk("R4 data stall C2", 64'(sd), 1);
    chk("R11 valids C2", 64'(vld), 64'(3'b011));
    @(negedge clk);
    chk("R4 data stall C3", 64'(sd), 1);
    chk("R11 valids C3", 64'(vld), 64'(3'b101));
    chk("R11 decode pc C3", 64'(spc[AW-1:0]), 1);
    @(negedge clk);
    chk("R4 stall released C4", 64'(sd), 0);

    // R2 R3 exact port conflict timing
    start(0);
    @(negedge clk); @(negedge clk);
    chk("R2 mem stall one-port C2", 64'(sm), 1);
    chk("R3 no mem stall two-port C2", 64'(sm2), 0);
    @(negedge clk);
    chk("R2 pc held C3", 64'(pc), 2);

    // R5 exact jump timing
    start(2);
    @(negedge clk);
    chk("R5 flush on jump decode", 64'(fl), 1);
    @(negedge clk);
    chk("R5 pipe emptied", 64'(vld), 0);
    chk("R5 pc at target", 64'(pc), 4);

    // R6 exact interrupt entry timing
    start(3);
    @(negedge clk); irq = 1'b1;
    @(negedge clk); irq = 1'b0;
    @(negedge clk);
    chk("R6 flush on entry", 64'(fl), 1);
    @(negedge clk);
    chk("R6 pc at vector", 64'(pc), 32);
    chk("R6 epc oldest pending", 64'(epc), 1);
    chk("R6 stages emptied", 64'(vld), 0);
    chk("R6 executing instr completed", 64'(regs[15:0]), 1);

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule